// File: doc/BRIEF.md
# Dual-Link LVDS Lane Distributor

This block takes one pixel per clock from the lane-word generator and sends it to two LVDS output links. Each pixel arrives as five 7-bit lane words. In single-link mode every pixel with data-enable high goes to link 1 on the next clock, and link 2 stays at zero. In dual-link mode pixels are paired. The first pixel after data-enable rises is even and the next one is odd. Once both are captured, they go to the two links together on one strobe, so each link runs at half the pixel rate.

A phase input decides which link gets the even pixel. Each link has its own crossbar. For each of its five output lanes, a 4-bit select field picks one of ten internal lane sources or a constant zero. A per-lane inversion bit then complements the selected word. If data-enable falls after an odd number of pixels, the last pair is completed with a blank pixel, so no pixel is lost. Serialization and clock generation happen downstream.

Top module: `lvds_lane_dist`

## Requirements
- R1: While `rst_ni` is low and on the first cycle after release, `vld_o` is 0 and both link outputs are all zero.
- R2: With `dual_mode_i`=0, every clock with `de_i`=1 gives `vld_o`=1 on the following clock. Link 1 shows the crossbar result for that pixel. In this mode sources 0..4 are input lane words 0..4 (word k at `pix_i[7k+6:7k]`) and sources 5..9 are zero.
- R3: With `dual_mode_i`=0, `link2_o` is all zero on every result, whatever `dist2_i`, `inv2_i` and `link_phase_i` hold.
- R4: With `dual_mode_i`=1, the first pixel after `de_i` rises is pixel 0 (even). A result appears on the clock after each odd pixel, so `vld_o` pulses once per two input pixels and never on two clocks in a row.
- R5: In dual mode with `link_phase_i`=0, sources 0..4 are the even pixel's words and sources 5..9 are the odd pixel's words. With `link_phase_i`=1 the two pixels swap places.
- R6: In dual mode, if `de_i` is low on the clock after an even pixel, a result appears on the following clock with the odd pixel replaced by all-zero words.
- R7: Output lane j of a link takes the source named by bits [4j+3:4j] of that link's select word. Select values 10..15 give a zero word.
- R8: Bit j of `inv1_i` (or `inv2_i`) complements all seven bits of lane j of link 1 (or link 2) after selection.
- R9: Between results the link outputs hold their last value, and `vld_o` stays 0 whenever no result is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| dual_mode_i | input | 1 | 0 = single link, 1 = dual link |
| link_phase_i | input | 1 | 0 = even pixel to link 1, 1 = odd pixel to link 1 |
| de_i | input | 1 | Data enable for the incoming pixel |
| pix_i | input | 35 | Five 7-bit lane words of one pixel |
| dist1_i | input | 20 | Link 1 lane select fields, 4 bits per output lane |
| dist2_i | input | 20 | Link 2 lane select fields, 4 bits per output lane |
| inv1_i | input | 5 | Link 1 per-lane inversion |
| inv2_i | input | 5 | Link 2 per-lane inversion |
| vld_o | output | 1 | One-clock strobe marking a new result on both links |
| link1_o | output | 35 | Link 1 lane words |
| link2_o | output | 35 | Link 2 lane words |

## Verification
The bench aims at the cases most likely to go wrong:
- **Blank fill:** a burst with an odd number of pixels. A design that dropped the trailing pixel, or waited for the next burst, would give a missing or late strobe.
- **Phase swap and pairing:** the phase swap, and pairing restarting at each rise of data-enable. A mistake here shows up as even and odd words landing on the wrong link.
- **Crossbar corners:** select codes 10 to 15 and all-lane inversion. An off-by-one lane select, or inversion applied before the mux, would put the wrong word on a lane.
- **Idle link and hold:** link 2 in single mode, and the hold between strobes. A design that leaked the link 2 crossbar output in single mode, or let outputs drift between results, would be caught here.

Random bursts with random configuration then compare every clock against a model written from the requirements.

// File: rtl/lvds_dist_pkg.sv
package lvds_dist_pkg;
   // lane words per pixel and bits per lane word
   localparam int unsigned LANES_DEF  = 5;
   localparam int unsigned WORD_W_DEF = 7;
   localparam int unsigned SEL_W_DEF  = 4;

   typedef enum logic {
      LINK_SINGLE = 1'b0,
      LINK_DUAL   = 1'b1
   } link_mode_e;

   // number of crossbar sources: two pixels of lane words
   function automatic int unsigned src_count(input int unsigned lanes);
      return 2 * lanes;
   endfunction
endpackage

// File: rtl/lvds_pair_capture.sv
module lvds_pair_capture
   import lvds_dist_pkg::*;
#(
   parameter int unsigned LANES  = LANES_DEF,
   parameter int unsigned WORD_W = WORD_W_DEF,
   localparam int unsigned PIX_W = LANES * WORD_W
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               dual_i,
   input  logic               phase_i,
   input  logic               de_i,
   input  logic [PIX_W-1:0]   pix_i,
   output logic               emit_o,
   output logic [2*PIX_W-1:0] src_o
);
   logic             odd_pos_q;
   logic [PIX_W-1:0] hold_q;
   logic [PIX_W-1:0] even_pix, odd_pix;
   logic [PIX_W-1:0] first_pix, second_pix;
   link_mode_e       mode;

   assign mode = link_mode_e'(dual_i);

   always_comb begin
      emit_o   = 1'b0;
      even_pix = '0;
      odd_pix  = '0;
      if (mode == LINK_SINGLE) begin
         emit_o   = de_i;
         even_pix = pix_i;
      end else if (odd_pos_q) begin
         // pair completes: real odd pixel, or blank when DE dropped
         emit_o   = 1'b1;
         even_pix = hold_q;
         odd_pix  = de_i ? pix_i : '0;
      end
   end

   always_comb begin
      if (mode == LINK_DUAL && phase_i) begin
         first_pix  = odd_pix;
         second_pix = even_pix;
      end else begin
         first_pix  = even_pix;
         second_pix = odd_pix;
      end
   end

   assign src_o = {second_pix, first_pix};

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         odd_pos_q <= 1'b0;
         hold_q    <= '0;
      end else if (mode == LINK_SINGLE) begin
         odd_pos_q <= 1'b0;
      end else if (odd_pos_q) begin
         odd_pos_q <= 1'b0;
      end else if (de_i) begin
         odd_pos_q <= 1'b1;
         hold_q    <= pix_i;
      end
   end

   // R4
   odd_rise_de_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(odd_pos_q) |-> ($past(de_i) && $past(dual_i)));

   // R4
   pair_no_b2b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (emit_o && dual_i) |=> (!emit_o || !dual_i));
endmodule

// File: rtl/lvds_lane_xbar.sv
module lvds_lane_xbar
   import lvds_dist_pkg::*;
#(
   parameter int unsigned LANES  = LANES_DEF,
   parameter int unsigned WORD_W = WORD_W_DEF,
   parameter int unsigned SEL_W  = SEL_W_DEF,
   localparam int unsigned SRC_N = src_count(LANES),
   localparam int unsigned PIX_W = LANES * WORD_W
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic                     load_i,
   input  logic                     idle_i,
   input  logic [SRC_N*WORD_W-1:0]  src_i,
   input  logic [LANES*SEL_W-1:0]   dist_i,
   input  logic [LANES-1:0]         inv_i,
   output logic [PIX_W-1:0]         lanes_o
);
   logic [WORD_W-1:0] src_a [SRC_N];
   logic [PIX_W-1:0]  lanes_d;
   logic [PIX_W-1:0]  lanes_q;

   for (genvar s = 0; s < SRC_N; s++) begin : g_unpack
      assign src_a[s] = src_i[s*WORD_W +: WORD_W];
   end

   for (genvar j = 0; j < LANES; j++) begin : g_lane
      logic [SEL_W-1:0]  sel;
      logic [WORD_W-1:0] picked;

      assign sel = dist_i[j*SEL_W +: SEL_W];

      always_comb begin
         picked = '0;
         for (int s = 0; s < SRC_N; s++) begin
            if (sel == SEL_W'(s)) picked = src_a[s];
         end
      end

      assign lanes_d[j*WORD_W +: WORD_W] = picked ^ {WORD_W{inv_i[j]}};

      // R7
      const_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (load_i && !idle_i && (sel >= SEL_W'(SRC_N)) && !inv_i[j])
         |=> (lanes_o[j*WORD_W +: WORD_W] == '0));
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni)      lanes_q <= '0;
      else if (load_i)  lanes_q <= idle_i ? '0 : lanes_d;
   end

   assign lanes_o = lanes_q;

   // R3
   idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (load_i && idle_i) |=> (lanes_o == '0));

   // R9
   hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !load_i |=> $stable(lanes_o));
endmodule

// File: rtl/lvds_lane_dist.sv
module lvds_lane_dist
   import lvds_dist_pkg::*;
#(
   parameter int unsigned LANES  = LANES_DEF,
   parameter int unsigned WORD_W = WORD_W_DEF,
   parameter int unsigned SEL_W  = SEL_W_DEF,
   localparam int unsigned SRC_N = src_count(LANES),
   localparam int unsigned PIX_W = LANES * WORD_W,
   localparam int unsigned DST_W = LANES * SEL_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              dual_mode_i,
   input  logic              link_phase_i,
   input  logic              de_i,
   input  logic [PIX_W-1:0]  pix_i,
   input  logic [DST_W-1:0]  dist1_i,
   input  logic [DST_W-1:0]  dist2_i,
   input  logic [LANES-1:0]  inv1_i,
   input  logic [LANES-1:0]  inv2_i,
   output logic              vld_o,
   output logic [PIX_W-1:0]  link1_o,
   output logic [PIX_W-1:0]  link2_o
);
   if (SRC_N > (1 << SEL_W)) begin : g_bad_sel
      $error("select field too narrow for %0d sources", SRC_N);
   end
   if (WORD_W == 0 || LANES == 0) begin : g_bad_dim
      $error("lane count and word width must be nonzero");
   end

   logic               emit;
   logic [2*PIX_W-1:0] src;
   logic               vld_q;

   lvds_pair_capture #(.LANES(LANES), .WORD_W(WORD_W)) u_cap (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .dual_i  (dual_mode_i),
      .phase_i (link_phase_i),
      .de_i    (de_i),
      .pix_i   (pix_i),
      .emit_o  (emit),
      .src_o   (src)
   );

   lvds_lane_xbar #(.LANES(LANES), .WORD_W(WORD_W), .SEL_W(SEL_W)) u_xbar1 (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (emit),
      .idle_i  (1'b0),
      .src_i   (src),
      .dist_i  (dist1_i),
      .inv_i   (inv1_i),
      .lanes_o (link1_o)
   );

   lvds_lane_xbar #(.LANES(LANES), .WORD_W(WORD_W), .SEL_W(SEL_W)) u_xbar2 (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (emit),
      .idle_i  (!dual_mode_i),
      .src_i   (src),
      .dist_i  (dist2_i),
      .inv_i   (inv2_i),
      .lanes_o (link2_o)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) vld_q <= 1'b0;
      else         vld_q <= emit;
   end

   assign vld_o = vld_q;

   // R3
   single_link2_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vld_o && !$past(dual_mode_i)) |-> (link2_o == '0));

   // R9
   no_vld_without_input_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!$past(de_i) && !$past(dual_mode_i)) |-> !vld_o);
endmodule

// File: tb/sim_lvds_lane_dist.sv
`timescale 1ns/1ps
module sim_lvds_lane_dist;
   localparam int LANES = 5;
   localparam int WW    = 7;
   localparam int PW    = LANES * WW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          dual = 1'b0, phase = 1'b0, de = 1'b0;
   logic [PW-1:0] pix = '0;
   logic [19:0]   dist1 = 20'h04321, dist2 = 20'h59876;
   logic [4:0]    inv1 = '0, inv2 = '0;
   logic          vld;
   logic [PW-1:0] l1, l2;

   int checks = 0;
   int errors = 0;

   // model state
   logic          m_odd = 1'b0;
   logic [PW-1:0] m_hold = '0;
   logic          e_vld = 1'b0;
   logic [PW-1:0] e_l1 = '0, e_l2 = '0;

   always #2.5 clk = ~clk;

   lvds_lane_dist u0 (
      .clk_i(clk), .rst_ni(rst_n), .dual_mode_i(dual), .link_phase_i(phase),
      .de_i(de), .pix_i(pix), .dist1_i(dist1), .dist2_i(dist2),
      .inv1_i(inv1), .inv2_i(inv2), .vld_o(vld), .link1_o(l1), .link2_o(l2)
   );

   function automatic logic [PW-1:0] xbar_f(input logic [2*PW-1:0] s,
                                            input logic [19:0] d,
                                            input logic [4:0] iv);
      logic [PW-1:0] r;
      r = '0;
      for (int j = 0; j < LANES; j++) begin
         logic [3:0]    sel;
         logic [WW-1:0] w;
         sel = d[4*j +: 4];
         w = (sel < 4'd10) ? s[WW*sel +: WW] : '0;
         if (iv[j]) w = ~w;
         r[WW*j +: WW] = w;
      end
      return r;
   endfunction

   task automatic check(input string tag, input string what,
                        input logic [PW-1:0] act, input logic [PW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
      end
   endtask

   // drive one pixel at negedge, advance one clock, compare at next negedge
   task automatic tick(input string tag, input logic d, input logic [PW-1:0] p);
      logic          emit;
      logic [PW-1:0] ev, od, first, second;
      de = d; pix = p;
      emit = 1'b0; ev = '0; od = '0;
      if (!dual) begin
         emit = d; ev = p; m_odd = 1'b0;
      end else if (m_odd) begin
         emit = 1'b1; ev = m_hold; od = d ? p : '0; m_odd = 1'b0;
      end else if (d) begin
         m_hold = p; m_odd = 1'b1;
      end
      if (dual && phase) begin first = od; second = ev; end
      else begin first = ev; second = od; end
      e_vld = emit;
      if (emit) begin
         e_l1 = xbar_f({second, first}, dist1, inv1);
         e_l2 = dual ? xbar_f({second, first}, dist2, inv2) : '0;
      end
      @(posedge clk); @(negedge clk);
      check(tag, "vld", PW'(vld), PW'(e_vld));
      check(tag, "link1", l1, e_l1);
      check(tag, "link2", l2, e_l2);
   endtask

   function automatic logic [PW-1:0] rpix();
      return {$urandom(), $urandom()};
   endfunction

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1", "vld", PW'(vld), '0);
      check("R1", "link1", l1, '0);
      check("R1", "link2", l2, '0);
      rst_n = 1'b1;
      tick("R1", 1'b0, '0);

      // R2 single mode, default selects; R3 link2 idle despite config
      inv2 = 5'h1f; phase = 1'b1;
      tick("R2", 1'b1, 35'h1_2345_6789);
      tick("R3", 1'b1, 35'h7_ffff_0000);
      tick("R9", 1'b0, 35'h5_5555_5555);
      tick("R9", 1'b0, 35'h2_aaaa_aaaa);
      phase = 1'b0; inv2 = '0;

      // R7 constant-zero selects and field positions
      dist1 = 20'hA_F_5_0_4;
      tick("R7", 1'b1, rpix());
      dist1 = 20'hC_B_E_D_3;
      tick("R7", 1'b1, rpix());
      // R8 inversion on selected and constant lanes
      inv1 = 5'b10101;
      tick("R8", 1'b1, rpix());
      inv1 = 5'h1f; dist1 = 20'h04321;
      tick("R8", 1'b1, rpix());
      tick("R8", 1'b0, '0);
      inv1 = '0;

      // R4/R5 dual mode, phase 0, even count
      dual = 1'b1; phase = 1'b0;
      tick("R4", 1'b1, rpix());
      tick("R4", 1'b1, rpix());
      tick("R5", 1'b1, rpix());
      tick("R5", 1'b1, rpix());
      tick("R9", 1'b0, '0);
      tick("R9", 1'b0, rpix());
      // R5 phase 1
      phase = 1'b1; inv2 = 5'b01001;
      tick("R5", 1'b1, rpix());
      tick("R5", 1'b1, rpix());
      // R6 odd count: blank fill
      tick("R6", 1'b1, rpix());
      tick("R6", 1'b0, rpix());
      tick("R6", 1'b0, '0);
      phase = 1'b0;
      tick("R6", 1'b1, rpix());
      tick("R6", 1'b1, rpix());
      tick("R6", 1'b1, rpix());
      tick("R6", 1'b0, '0);
      tick("R9", 1'b0, '0);

      // random bursts with random configuration between bursts
      for (int b = 0; b < 300; b++) begin
         int len;
         dual  = $urandom_range(0, 1);
         phase = $urandom_range(0, 1);
         dist1 = $urandom(); dist2 = $urandom();
         inv1  = $urandom(); inv2  = $urandom();
         len = $urandom_range(1, 9);
         for (int k = 0; k < len; k++)
            tick(dual ? "R5" : "R2", 1'b1, rpix());
         for (int k = 0; k < $urandom_range(1, 3); k++)
            tick(dual ? "R6" : "R9", 1'b0, rpix());
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule